// File: doc/BRIEF.md
# Multi-Format Float-to-Integer Converter

This unit turns one IEEE-754 binary floating-point operand into a 32-bit integer, always rounding to the nearest integer with ties going to the even neighbour. The source may be half, single or double precision, chosen by a 2-bit format code. The narrower formats sit in the low bits of a 64-bit operand bus, and the bits above them are ignored. A separate control bit chooses whether the destination is unsigned or two's-complement signed. Values that fall outside the destination range are clamped to the nearest bound. NaN, infinity, out-of-range and lossy conversions are reported through an invalid flag and an inexact flag.

The datapath is combinational and ends in one output register, so a result appears one clock after its inputs are presented. The unit takes a new operand every cycle. A format code with no meaning, and half precision while half support is switched off, both raise an undefined-request indication. In that case the result and both flags stay zero.

Top module: `fcvt_rne_i32`

## Requirements
- R1: The result, undefined indication and flags for the inputs present at a rising clock edge appear on the outputs after that edge. Rounding is to nearest, with exact halves going to the even integer (2.5 gives 2, 3.5 gives 4).
- R2: Format code 01 takes a half-precision source from operand bits [15:0]. Code 10 takes a single-precision source from bits [31:0]. Code 11 takes a double-precision source from all 64 bits. Operand bits above the selected width have no effect.
- R3: Format code 00 sets the undefined indication and gives result 0 with both flags clear.
- R4: Format code 01 with the half-enable input low behaves like R3. With the half-enable input high it converts normally.
- R5: When the signedness input is 0 the result is an unsigned 32-bit value. When it is 1 the result is a two's-complement 32-bit value.
- R6: A finite value whose rounded magnitude does not fit gives the nearest bound and sets invalid. Unsigned clamps to 0xFFFFFFFF for positive values. Signed clamps to 0x7FFFFFFF for positive values and 0x80000000 for negative values.
- R7: A NaN source gives result 0 with invalid set.
- R8: An infinite source gives the bound that matches its sign and sets invalid. For unsigned, +inf gives 0xFFFFFFFF and -inf gives 0.
- R9: Inexact is set exactly when an in-range conversion discards a nonzero fraction. Invalid and inexact are never set together.
- R10: A subnormal source of any format gives 0, with inexact set when the source is nonzero.
- R11: For an unsigned result, a negative source that rounds to zero gives 0 with only inexact (or with no flag for an exact zero). A negative source that rounds to -1 or below gives 0 with invalid set.
- R12: While the synchronous active-low reset is sampled low, the result, the undefined indication and both flags are cleared at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| operand | input | 64 | Floating-point source; narrower formats in the low bits |
| fmt_sel | input | 2 | Source format code (00 illegal, 01 half, 10 single, 11 double) |
| signed_sel | input | 1 | 0 for an unsigned destination, 1 for a signed destination |
| half_en | input | 1 | Allows format code 01 when high |
| result | output | OUT_W | Converted integer |
| undef_req | output | 1 | Format code rejected; no conversion performed |
| flag_invalid | output | 1 | NaN, infinity or out-of-range source |
| flag_inexact | output | 1 | Nonzero fraction discarded in an in-range conversion |

## Verification
The bench builds the unit with its default destination width of 32 bits. At that width, double-precision sources can land exactly on each side of every clamp bound, including ties sitting half a unit past 0xFFFFFFFF and 0x7FFFFFFF. Half-precision sources can reach the bounds only through infinity, because the largest finite half is 65504. Single and half sources carry junk in the unused upper operand bits. A randomized stream biases exponents into the rounding-sensitive range so that ties, subnormals and overflows mix across all four format codes.

// File: rtl/fcvt_pkg.sv
// Package: shared constants, source-format table and the unpacked operand
// record used between the decode and rounding stages of the converter.
// Assumes IEEE-754 binary16/32/64 layouts packed at bit 0 of a 64-bit bus.
package fcvt_pkg;

    localparam int SRC_W   = 64;  // width of the operand bus
    localparam int NUM_FMT = 3;   // half, single, double
    localparam int K_W     = 13;  // signed unbiased-exponent width

    typedef enum logic [1:0] {
        FMT_BAD    = 2'b00,
        FMT_HALF   = 2'b01,
        FMT_SINGLE = 2'b10,
        FMT_DOUBLE = 2'b11
    } fmt_code_e;

    // Decoded source: mant is left-aligned so that bit SRC_W-1 has weight 2^k.
    typedef struct packed {
        logic                  sign;
        logic                  is_nan;
        logic                  is_inf;
        logic signed [K_W-1:0] k;
        logic [SRC_W-1:0]      mant;
    } fp_unpacked_t;

    // Exponent field width of format slot idx (0 half, 1 single, 2 double).
    function automatic int exp_width(int idx);
        case (idx)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    // Stored fraction width of format slot idx.
    function automatic int frac_width(int idx);
        case (idx)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/fcvt_unpack.sv
// Module: fcvt_unpack
// Decodes the operand in each of the three IEEE formats in parallel and
// selects the one named by fmt_sel. Subnormals use exponent 1 with no hidden
// bit. Illegal code 00 falls onto the half slot; the top level masks it.
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [SRC_W-1:0] operand,
    input  logic [1:0]       fmt_sel,
    output fp_unpacked_t     unp
);

    fp_unpacked_t cand [NUM_FMT];

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
        localparam int EW   = exp_width(f);
        localparam int FW   = frac_width(f);
        localparam int BIAS = (1 << (EW - 1)) - 1;

        logic [EW-1:0] exp_f;
        logic [EW-1:0] exp_eff;
        logic [FW-1:0] frac_f;
        logic          sign_f;
        logic          hid;

        // Field extraction for this format slot.
        assign exp_f   = operand[FW +: EW];
        assign frac_f  = operand[FW-1:0];
        assign sign_f  = operand[FW+EW];
        assign hid     = |exp_f;
        assign exp_eff = hid ? exp_f : EW'(1);

        // Build the normalised record for this slot.
        assign cand[f] = '{
            sign:   sign_f,
            is_nan: (&exp_f) & (|frac_f),
            is_inf: (&exp_f) & ~(|frac_f),
            k:      K_W'(exp_eff) - K_W'(BIAS),
            mant:   {hid, frac_f, {(SRC_W - 1 - FW){1'b0}}}
        };
    end

    // Pick the slot that matches the format code.
    always_comb begin
        case (fmt_sel)
            FMT_SINGLE: unp = cand[1];
            FMT_DOUBLE: unp = cand[2];
            default:    unp = cand[0];
        endcase
    end

endmodule

// File: rtl/fcvt_round.sv
// Module: fcvt_round
// Splits the left-aligned mantissa at the binary point given by k and rounds
// the integer part to nearest, ties to even. Flags magnitudes of 2^OUT_W or
// more as too_big without forming them. Assumes OUT_W < SRC_W - 1.
module fcvt_round
    import fcvt_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic signed [K_W-1:0] k,
    input  logic [SRC_W-1:0]      mant,
    output logic [OUT_W:0]        mag,
    output logic                  too_big,
    output logic                  lost_frac
);

    localparam int MAG_W = OUT_W + 1;
    localparam int MSB   = SRC_W - 1;

    logic [MAG_W-1:0] int_bits;
    logic [SRC_W-1:0] frac_bits;
    logic             guard;
    logic             sticky;
    int               kk;

    // Integer/fraction split with guard and sticky extraction.
    always_comb begin
        kk        = int'(k);
        too_big   = 1'b0;
        int_bits  = '0;
        frac_bits = '0;
        guard     = 1'b0;
        sticky    = 1'b0;
        if (kk >= OUT_W) begin
            too_big = 1'b1;
        end else if (kk >= 0) begin
            int_bits  = MAG_W'(mant >> (MSB - kk));
            frac_bits = mant << (kk + 1);
            guard     = frac_bits[MSB];
            sticky    = |frac_bits[MSB-1:0];
        end else if (kk == -1) begin
            guard  = mant[MSB];
            sticky = |mant[MSB-1:0];
        end else begin
            sticky = |mant;
        end
    end

    // Round to nearest even on the integer part.
    always_comb begin
        mag       = int_bits + MAG_W'(guard & (sticky | int_bits[0]));
        lost_frac = guard | sticky;
    end

endmodule

// File: rtl/fcvt_saturate.sv
// Module: fcvt_saturate
// Applies the sign and destination range to a rounded magnitude. Produces
// the clamped integer, invalid for NaN/infinity/overflow, and inexact only
// for in-range results. Assumes mag already carries round-to-nearest-even.
module fcvt_saturate #(
    parameter int OUT_W = 32
) (
    input  logic             sign,
    input  logic             is_nan,
    input  logic             is_inf,
    input  logic             too_big,
    input  logic             signed_sel,
    input  logic [OUT_W:0]   mag,
    input  logic             lost_frac,
    output logic [OUT_W-1:0] value,
    output logic             invalid,
    output logic             inexact
);

    localparam int               MAG_W = OUT_W + 1;
    localparam logic [OUT_W-1:0] UMAX  = {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] SMAX  = {1'b0, {(OUT_W - 1){1'b1}}};
    localparam logic [OUT_W-1:0] SMIN  = {1'b1, {(OUT_W - 1){1'b0}}};

    // Range check and clamp selection.
    always_comb begin
        value   = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        if (is_nan) begin
            invalid = 1'b1;
        end else if (is_inf || too_big) begin
            invalid = 1'b1;
            if (signed_sel) value = sign ? SMIN : SMAX;
            else            value = sign ? '0 : UMAX;
        end else if (!signed_sel) begin
            if (sign) begin
                if (mag != '0) invalid = 1'b1;
                else           inexact = lost_frac;
            end else if (mag[OUT_W]) begin
                invalid = 1'b1;
                value   = UMAX;
            end else begin
                value   = mag[OUT_W-1:0];
                inexact = lost_frac;
            end
        end else begin
            if (sign) begin
                if (mag > MAG_W'(SMIN)) begin
                    invalid = 1'b1;
                    value   = SMIN;
                end else begin
                    value   = -mag[OUT_W-1:0];
                    inexact = lost_frac;
                end
            end else if (mag > MAG_W'(SMAX)) begin
                invalid = 1'b1;
                value   = SMAX;
            end else begin
                value   = mag[OUT_W-1:0];
                inexact = lost_frac;
            end
        end
    end

endmodule

// File: rtl/fcvt_rne_i32.sv
// Module: fcvt_rne_i32 (top)
// Converts a half/single/double operand to an OUT_W-bit integer with
// round-to-nearest-even, saturation and IEEE flags. One output register
// stage. Rejects format code 00, and code 01 when half support is off.
module fcvt_rne_i32
    import fcvt_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      operand,
    input  logic [1:0]       fmt_sel,
    input  logic             signed_sel,
    input  logic             half_en,
    output logic [OUT_W-1:0] result,
    output logic             undef_req,
    output logic             flag_invalid,
    output logic             flag_inexact
);

    fp_unpacked_t     unp;
    logic [OUT_W:0]   mag;
    logic             too_big;
    logic             lost_frac;
    logic [OUT_W-1:0] value;
    logic             invalid;
    logic             inexact;
    logic             fmt_ok;

    fcvt_unpack u_unpack (
        .operand (operand),
        .fmt_sel (fmt_sel),
        .unp     (unp)
    );

    fcvt_round #(.OUT_W(OUT_W)) u_round (
        .k         (unp.k),
        .mant      (unp.mant),
        .mag       (mag),
        .too_big   (too_big),
        .lost_frac (lost_frac)
    );

    fcvt_saturate #(.OUT_W(OUT_W)) u_sat (
        .sign       (unp.sign),
        .is_nan     (unp.is_nan),
        .is_inf     (unp.is_inf),
        .too_big    (too_big),
        .signed_sel (signed_sel),
        .mag        (mag),
        .lost_frac  (lost_frac),
        .value      (value),
        .invalid    (invalid),
        .inexact    (inexact)
    );

    // Format legality: code 00 never, half only when enabled.
    always_comb begin
        fmt_ok = (fmt_sel != FMT_BAD) && !((fmt_sel == FMT_HALF) && !half_en);
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            undef_req    <= 1'b0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else if (!fmt_ok) begin
            result       <= '0;
            undef_req    <= 1'b1;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            result       <= value;
            undef_req    <= 1'b0;
            flag_invalid <= invalid;
            flag_inexact <= inexact;
        end
    end

endmodule

// File: rtl/fcvt_rne_i32_chk.sv
// Module: fcvt_rne_i32_chk
// Temporal checks on the converter's ports, bound into every instance of
// fcvt_rne_i32. Relies on one register stage between inputs and outputs.
module fcvt_rne_i32_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [63:0]      operand,
    input logic [1:0]       fmt_sel,
    input logic             signed_sel,
    input logic             half_en,
    input logic [OUT_W-1:0] result,
    input logic             undef_req,
    input logic             flag_invalid,
    input logic             flag_inexact
);

    p_reset_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (result == '0 && !undef_req && !flag_invalid && !flag_inexact));

    p_undef_fmt0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'b00)
        |-> (undef_req && result == '0 && !flag_invalid && !flag_inexact));

    p_undef_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'b01 && !$past(half_en)) |-> undef_req);

    p_legal_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) != 2'b00
         && !($past(fmt_sel) == 2'b01 && !$past(half_en))) |-> !undef_req);

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_invalid && flag_inexact));

    p_nan_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'b11 && $past(operand[62:52]) == 11'h7FF
         && $past(operand[51:0]) != '0) |-> (result == '0 && flag_invalid));

    p_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(operand) == $past(operand, 2)
         && $past(fmt_sel) == $past(fmt_sel, 2) && $past(signed_sel) == $past(signed_sel, 2)
         && $past(half_en) == $past(half_en, 2))
        |-> ($stable(result) && $stable(undef_req) && $stable(flag_invalid)
             && $stable(flag_inexact)));

endmodule

bind fcvt_rne_i32 fcvt_rne_i32_chk #(.OUT_W(OUT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .operand      (operand),
    .fmt_sel      (fmt_sel),
    .signed_sel   (signed_sel),
    .half_en      (half_en),
    .result       (result),
    .undef_req    (undef_req),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
);

// File: tb/fcvt_rne_i32_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model built on real arithmetic, one
// expectation queued per driven cycle and compared on the following cycle.
module fcvt_rne_i32_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        signed_sel = 1'b0;
    logic        half_en = 1'b0;
    logic [31:0] result;
    logic        undef_req;
    logic        flag_invalid;
    logic        flag_inexact;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        undef;
        logic        inv;
        logic        inx;
    } expect_t;

    expect_t pend_q[$];
    string   tag_q[$];

    fcvt_rne_i32 #(.OUT_W(32)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .operand      (operand),
        .fmt_sel      (fmt_sel),
        .signed_sel   (signed_sel),
        .half_en      (half_en),
        .result       (result),
        .undef_req    (undef_req),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    always #2.5 clk = ~clk;

    // Reference: decode by field arithmetic, value as a real, then round and clamp.
    function automatic expect_t model(logic [63:0] op, logic [1:0] f, logic s, logic h);
        expect_t r;
        int ew, fw, bias, ex;
        longint unsigned e, fr, mant, emax;
        logic neg;
        real a, fl, d;
        longint rnd, lim;
        bit big, nan, inf, inx;
        r.res = '0; r.undef = 1'b0; r.inv = 1'b0; r.inx = 1'b0;
        big = 0; inx = 0; rnd = 0;
        if (f == 2'b00 || (f == 2'b01 && !h)) begin
            r.undef = 1'b1;
            return r;
        end
        case (f)
            2'b01:   begin ew = 5;  fw = 10; end
            2'b10:   begin ew = 8;  fw = 23; end
            default: begin ew = 11; fw = 52; end
        endcase
        bias = (1 << (ew - 1)) - 1;
        emax = (64'd1 << ew) - 1;
        e    = (op >> fw) & emax;
        fr   = op & ((64'd1 << fw) - 1);
        neg  = op[fw+ew];
        nan  = (e == emax) && (fr != 0);
        inf  = (e == emax) && (fr == 0);
        if (!nan && !inf) begin
            mant = (e == 0) ? fr : (fr | (64'd1 << fw));
            ex   = ((e == 0) ? 1 : int'(e)) - bias - fw;
            a    = real'(mant) * (2.0 ** ex);
            big  = a >= 8589934592.0;
            if (!big) begin
                fl  = $floor(a);
                d   = a - fl;
                rnd = longint'(fl);
                if (d > 0.5 || (d == 0.5 && rnd[0])) rnd = rnd + 1;
                inx = (d != 0.0);
            end
        end
        if (nan) begin
            r.inv = 1'b1;
        end else if (!s) begin
            if (neg) begin
                if (inf || big || rnd != 0) r.inv = 1'b1;
                else                        r.inx = inx;
            end else if (inf || big || rnd > 64'sh0FFFFFFFF) begin
                r.inv = 1'b1; r.res = 32'hFFFFFFFF;
            end else begin
                r.res = rnd[31:0]; r.inx = inx;
            end
        end else begin
            lim = neg ? 64'sd2147483648 : 64'sd2147483647;
            if (inf || big || rnd > lim) begin
                r.inv = 1'b1; r.res = neg ? 32'h80000000 : 32'h7FFFFFFF;
            end else begin
                r.res = neg ? 32'(-rnd) : rnd[31:0]; r.inx = inx;
            end
        end
        return r;
    endfunction

    // Compare the oldest pending expectation against the current outputs.
    task automatic compare_one();
        expect_t e;
        string t;
        if (pend_q.size() == 0) return;
        e = pend_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (result !== e.res || undef_req !== e.undef || flag_invalid !== e.inv
            || flag_inexact !== e.inx) begin
            failures++;
            $display("FAIL %s: got res=%h undef=%b inv=%b inx=%b expected res=%h undef=%b inv=%b inx=%b",
                     t, result, undef_req, flag_invalid, flag_inexact,
                     e.res, e.undef, e.inv, e.inx);
        end
    endtask

    // Drive one vector at a falling edge; its result is checked one cycle later.
    task automatic drive(logic [63:0] op, logic [1:0] f, logic s, logic h, string tag);
        @(negedge clk);
        compare_one();
        operand = op; fmt_sel = f; signed_sel = s; half_en = h;
        pend_q.push_back(model(op, f, s, h));
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk);
        compare_one();
    endtask

    task automatic check_cleared(string tag);
        checks++;
        if (result !== '0 || undef_req !== 1'b0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
            failures++;
            $display("FAIL %s: got res=%h undef=%b inv=%b inx=%b expected all zero",
                     tag, result, undef_req, flag_invalid, flag_inexact);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog: got still running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] rop;
        logic [1:0]  rf;
        operand = 64'h4014000000000000; fmt_sel = 2'b11; signed_sel = 1'b1; half_en = 1'b1;
        repeat (3) @(negedge clk);
        check_cleared("R12 reset state");
        rst_n = 1'b1;

        // R1 rounding, double source
        drive(64'h3FF0000000000000, 2'b11, 1'b0, 1'b0, "R1 double 1.0");
        drive(64'h3FF8000000000000, 2'b11, 1'b0, 1'b0, "R1 double 1.5 up");
        drive(64'h4004000000000000, 2'b11, 1'b0, 1'b0, "R1 double 2.5 tie even");
        drive(64'h400C000000000000, 2'b11, 1'b1, 1'b0, "R1 double 3.5 tie even");
        drive(64'h3FE0000000000000, 2'b11, 1'b1, 1'b0, "R1 double 0.5 to zero");
        // R5 signed results
        drive(64'hC004000000000000, 2'b11, 1'b1, 1'b0, "R5 double -2.5 signed");
        drive(64'hC1E0000000000000, 2'b11, 1'b1, 1'b0, "R5 double -2^31 exact");
        drive(64'hC1E0000000100000, 2'b11, 1'b1, 1'b0, "R5 double -2^31-0.5 tie");
        // R6 saturation
        drive(64'h41EFFFFFFFE00000, 2'b11, 1'b0, 1'b0, "R6 unsigned max exact");
        drive(64'h41EFFFFFFFF00000, 2'b11, 1'b0, 1'b0, "R6 unsigned tie overflows");
        drive(64'h41EFFFFFFFE00000, 2'b11, 1'b1, 1'b0, "R6 signed positive clamp");
        drive(64'h41DFFFFFFFE00000, 2'b11, 1'b1, 1'b0, "R6 signed tie overflows");
        drive(64'hC1E0000000200000, 2'b11, 1'b1, 1'b0, "R6 signed negative clamp");
        drive(64'h4415AF1D78B58C40, 2'b11, 1'b0, 1'b0, "R6 huge unsigned");
        // R7 / R8 special values
        drive(64'h7FF8000000000000, 2'b11, 1'b1, 1'b0, "R7 double NaN");
        drive(64'h000000007FC00000, 2'b10, 1'b0, 1'b0, "R7 single NaN");
        drive(64'h0000000000007E00, 2'b01, 1'b1, 1'b1, "R7 half NaN");
        drive(64'h7FF0000000000000, 2'b11, 1'b0, 1'b0, "R8 +inf unsigned");
        drive(64'hFFF0000000000000, 2'b11, 1'b1, 1'b0, "R8 -inf signed");
        drive(64'h00000000FF800000, 2'b10, 1'b0, 1'b0, "R8 single -inf unsigned");
        drive(64'h0000000000007C00, 2'b01, 1'b1, 1'b1, "R8 half +inf signed");
        // R9 / R10 inexact and subnormals
        drive(64'h0000000000000001, 2'b11, 1'b1, 1'b0, "R10 double subnormal");
        drive(64'hDEADBEEF00000001, 2'b10, 1'b0, 1'b0, "R10 single subnormal");
        drive(64'h0000000000000001, 2'b01, 1'b0, 1'b1, "R10 half subnormal");
        drive(64'h8000000000000000, 2'b11, 1'b0, 1'b0, "R9 negative zero exact");
        // R11 unsigned negatives
        drive(64'hBFD3333333333333, 2'b11, 1'b0, 1'b0, "R11 -0.3 unsigned");
        drive(64'hBFE0000000000000, 2'b11, 1'b0, 1'b0, "R11 -0.5 unsigned");
        drive(64'hBFF0000000000000, 2'b11, 1'b0, 1'b0, "R11 -1.0 unsigned");
        // R2 narrower formats with junk upper bits
        drive(64'hDEADBEEF3FC00000, 2'b10, 1'b0, 1'b0, "R2 single 1.5");
        drive(64'hFFFFFFFF40200000, 2'b10, 1'b0, 1'b0, "R2 single 2.5");
        drive(64'h12345678C0F00000, 2'b10, 1'b1, 1'b0, "R2 single -7.5 signed");
        drive(64'hFFFFFFFFFFFF3E00, 2'b01, 1'b0, 1'b1, "R2 half 1.5");
        drive(64'hA5A5A5A5A5A54100, 2'b01, 1'b0, 1'b1, "R2 half 2.5");
        drive(64'h000000000000C300, 2'b01, 1'b1, 1'b1, "R2 half -3.5 signed");
        drive(64'h0000000000007BFF, 2'b01, 1'b0, 1'b1, "R2 half max finite");
        // R3 / R4 rejection
        drive(64'h3FF0000000000000, 2'b00, 1'b0, 1'b1, "R3 format 00");
        drive(64'h7FF8000000000000, 2'b00, 1'b1, 1'b0, "R3 format 00 NaN bits");
        drive(64'h0000000000003C00, 2'b01, 1'b0, 1'b0, "R4 half disabled");
        drive(64'h0000000000003C00, 2'b01, 1'b0, 1'b1, "R4 half enabled");
        flush();

        // R12 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        operand = 64'h3FF0000000000000; fmt_sel = 2'b11; signed_sel = 1'b0;
        @(negedge clk);
        check_cleared("R12 reset mid-run");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 randomized stream with exponents near the integer range
        for (int i = 0; i < 3000; i++) begin
            rop = {$urandom, $urandom};
            rf  = 2'($urandom % 4);
            if (($urandom % 4) != 0) begin
                case (rf)
                    2'b11:   rop[62:52] = 11'(1019 + ($urandom % 40));
                    2'b10:   rop[30:23] = 8'(123 + ($urandom % 40));
                    default: rop[14:10] = 5'($urandom % 32);
                endcase
            end
            drive(rop, rf, 1'($urandom % 2), 1'($urandom % 4 != 0), "R1 R5 random");
        end
        flush();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule